// File: doc/BRIEF.md
# Two-Stage Priority Track Selector

This block reduces two groups of track candidates to two result words. One group carries high-category candidates and the other carries low-category candidates. Each group has `NCAND` entries, six by default. Every candidate has a valid flag, a sign bit, a momentum magnitude and a hit identifier. The position of an entry in its group (index 0 to `NCAND-1`) becomes the candidate's position code.

Each group first passes through its own ranking stage, which keeps the two candidates with the largest magnitude. A merge stage then lets category decide before magnitude. It fills the primary and secondary words from the four survivors. The block is a three-register pipeline that accepts a new set of candidates on every clock. It is meant to sit between the per-sub-matrix decoders and an output serializer.

Internally there is no sequencing state. The merge stage classifies each cycle into one of three enumerated cases:
- `MG_BOTH_HIGH`: the second-best high candidate is present.
- `MG_HIGH_LOW`: only one high candidate is present.
- `MG_BOTH_LOW`: no high candidate is present.

The case is chosen again every cycle from the registered survivors. No transition depends on history.

Top module: `tps_track_sel`

## Requirements
- R1: While reset is asserted and in the first cycles after it, both output words are all zeros, whatever the inputs hold.
- R2: Within each group, the ranking stage keeps the present candidate with the largest magnitude as first choice and the largest of the remaining present candidates as second choice.
- R3: When two present candidates in a group have equal magnitude, the one with the higher index ranks above the other.
- R4: A candidate with its valid flag at 0 ranks below every present candidate and never reaches an output, whatever its sign, magnitude or hit identifier.
- R5: When two or more high candidates are present, the primary word carries the best high candidate and the secondary word carries the second-best high candidate.
- R6: When exactly one high candidate is present, the primary word carries it and the secondary word carries the best low candidate.
- R7: When no high candidate is present, the primary word carries the best low candidate and the secondary word carries the second-best low candidate.
- R8: A word for a present candidate is laid out as follows. Bit 9 is the category (1 for high, 0 for low). Bit 8 is the sign (1 for positive, 0 for negative). Bits 7:4 are the magnitude. Bits 3:1 are the position code, equal to index plus one. Bit 0 is the hit identifier.
- R9: A word with no candidate behind it is all zeros, so a position code of 000 always means no hit.
- R10: Each set of inputs appears at the outputs exactly three clock cycles after it is sampled, and a new set is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_vld | input | NCAND | Valid flags of the high group |
| hi_sgn | input | NCAND | Sign bits of the high group (1 = positive) |
| hi_mag | input | NCAND*4 | Magnitudes of the high group; entry i sits at bits 4i+3:4i |
| hi_hid | input | NCAND | Hit identifiers of the high group |
| lo_vld | input | NCAND | Valid flags of the low group |
| lo_sgn | input | NCAND | Sign bits of the low group (1 = positive) |
| lo_mag | input | NCAND*4 | Magnitudes of the low group; entry i sits at bits 4i+3:4i |
| lo_hid | input | NCAND | Hit identifiers of the low group |
| prim_word | output | 10 | Primary result word |
| sec_word | output | 10 | Secondary result word |

## Verification
The bench builds the block with its default of six candidates per group, 4-bit magnitudes and a 1-bit hit identifier. With that size, every one of the 4096 combinations of high and low valid masks can be streamed through the pipeline, each with fresh magnitudes. This covers every split between the three merge cases and every placement of absent entries. Further passes draw magnitudes from a narrow range, which forces frequent ties. They also load absent entries with the maximum magnitude, so the index tie-break and the ranking of absent entries are both exercised against an arithmetic model.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int TPS_NCAND  = 6;
    localparam int TPS_MAG_W  = 4;
    localparam int TPS_HID_W  = 1;
    localparam int TPS_POS_W  = $clog2(TPS_NCAND + 1);
    localparam int TPS_WORD_W = 2 + TPS_MAG_W + TPS_POS_W + TPS_HID_W;

    typedef struct packed {
        logic                 vld;
        logic                 sgn;
        logic [TPS_MAG_W-1:0] mag;
        logic [TPS_HID_W-1:0] hid;
    } cand_t;

    typedef struct packed {
        logic                 vld;
        logic                 sgn;
        logic [TPS_MAG_W-1:0] mag;
        logic [TPS_HID_W-1:0] hid;
        logic [TPS_POS_W-1:0] pos;
    } pick_t;

    typedef enum logic [1:0] {
        MG_BOTH_LOW  = 2'd0,
        MG_HIGH_LOW  = 2'd1,
        MG_BOTH_HIGH = 2'd2
    } merge_e;

    // Output word: {category, sign, magnitude, position, hit id}; absent -> all zeros
    function automatic logic [TPS_WORD_W-1:0] tps_pack(input logic cat, input pick_t p);
        if (!p.vld) return '0;
        return {cat, p.sgn, p.mag, p.pos, p.hid};
    endfunction

endpackage

// File: rtl/tps_sel_n2.sv
module tps_sel_n2
    import tps_pkg::*;
#(
    parameter int NCAND = TPS_NCAND
) (
    input  cand_t [NCAND-1:0] cands,
    output pick_t             first,
    output pick_t             second
);

    localparam int IDX_W = (NCAND > 1) ? $clog2(NCAND) : 1;
    localparam int KEY_W = 1 + TPS_MAG_W + IDX_W;

    // Rank key: presence, then magnitude, then index (higher index wins ties)
    logic [KEY_W-1:0] key [NCAND];

    for (genvar gi = 0; gi < NCAND; gi++) begin : g_key
        assign key[gi] = {cands[gi].vld, cands[gi].mag, IDX_W'(gi)};
    end

    logic [IDX_W-1:0] best_i, next_i;
    logic [KEY_W-1:0] best_k, next_k;
    logic             next_have;

    always_comb begin
        best_i = '0;
        best_k = key[0];
        for (int i = 1; i < NCAND; i++) begin
            if (key[i] > best_k) begin
                best_i = IDX_W'(i);
                best_k = key[i];
            end
        end
        next_have = 1'b0;
        next_i    = '0;
        next_k    = '0;
        for (int i = 0; i < NCAND; i++) begin
            if ((IDX_W'(i) != best_i) && (!next_have || (key[i] > next_k))) begin
                next_have = 1'b1;
                next_i    = IDX_W'(i);
                next_k    = key[i];
            end
        end
    end

    always_comb begin
        first.vld  = cands[best_i].vld;
        first.sgn  = cands[best_i].sgn;
        first.mag  = cands[best_i].mag;
        first.hid  = cands[best_i].hid;
        first.pos  = cands[best_i].vld ? TPS_POS_W'(best_i) + TPS_POS_W'(1) : '0;
        second.vld = next_have & cands[next_i].vld;
        second.sgn = cands[next_i].sgn;
        second.mag = cands[next_i].mag;
        second.hid = cands[next_i].hid;
        second.pos = second.vld ? TPS_POS_W'(next_i) + TPS_POS_W'(1) : '0;
    end

endmodule

// File: rtl/tps_merge.sv
module tps_merge
    import tps_pkg::*;
(
    input  pick_t                  hi_first,
    input  pick_t                  hi_second,
    input  pick_t                  lo_first,
    input  pick_t                  lo_second,
    output logic [TPS_WORD_W-1:0]  prim,
    output logic [TPS_WORD_W-1:0]  sec
);

    merge_e mode;

    always_comb begin
        if (hi_second.vld)     mode = MG_BOTH_HIGH;
        else if (hi_first.vld) mode = MG_HIGH_LOW;
        else                   mode = MG_BOTH_LOW;
    end

    always_comb begin
        unique case (mode)
            MG_BOTH_HIGH: begin
                prim = tps_pack(1'b1, hi_first);
                sec  = tps_pack(1'b1, hi_second);
            end
            MG_HIGH_LOW: begin
                prim = tps_pack(1'b1, hi_first);
                sec  = tps_pack(1'b0, lo_first);
            end
            MG_BOTH_LOW: begin
                prim = tps_pack(1'b0, lo_first);
                sec  = tps_pack(1'b0, lo_second);
            end
            default: begin
                prim = '0;
                sec  = '0;
            end
        endcase
    end

endmodule

// File: rtl/tps_track_sel.sv
module tps_track_sel
    import tps_pkg::*;
#(
    parameter int NCAND = TPS_NCAND
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCAND-1:0]            hi_vld,
    input  logic [NCAND-1:0]            hi_sgn,
    input  logic [NCAND*TPS_MAG_W-1:0]  hi_mag,
    input  logic [NCAND*TPS_HID_W-1:0]  hi_hid,
    input  logic [NCAND-1:0]            lo_vld,
    input  logic [NCAND-1:0]            lo_sgn,
    input  logic [NCAND*TPS_MAG_W-1:0]  lo_mag,
    input  logic [NCAND*TPS_HID_W-1:0]  lo_hid,
    output logic [TPS_WORD_W-1:0]       prim_word,
    output logic [TPS_WORD_W-1:0]       sec_word
);

    // Stage 1: capture candidates
    cand_t [NCAND-1:0] hi_in, lo_in, hi_q, lo_q;

    for (genvar gi = 0; gi < NCAND; gi++) begin : g_unpack
        assign hi_in[gi] = '{vld: hi_vld[gi], sgn: hi_sgn[gi],
                             mag: hi_mag[gi*TPS_MAG_W +: TPS_MAG_W],
                             hid: hi_hid[gi*TPS_HID_W +: TPS_HID_W]};
        assign lo_in[gi] = '{vld: lo_vld[gi], sgn: lo_sgn[gi],
                             mag: lo_mag[gi*TPS_MAG_W +: TPS_MAG_W],
                             hid: lo_hid[gi*TPS_HID_W +: TPS_HID_W]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_in;
            lo_q <= lo_in;
        end
    end

    // Stage 2: per-group top-two ranking
    pick_t hi_a, hi_b, lo_a, lo_b;
    pick_t hi_a_q, hi_b_q, lo_a_q, lo_b_q;

    tps_sel_n2 #(.NCAND(NCAND)) u_sel_hi (.cands(hi_q), .first(hi_a), .second(hi_b));
    tps_sel_n2 #(.NCAND(NCAND)) u_sel_lo (.cands(lo_q), .first(lo_a), .second(lo_b));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_a_q <= '0;
            hi_b_q <= '0;
            lo_a_q <= '0;
            lo_b_q <= '0;
        end else begin
            hi_a_q <= hi_a;
            hi_b_q <= hi_b;
            lo_a_q <= lo_a;
            lo_b_q <= lo_b;
        end
    end

    // Stage 3: category-first merge, registered outputs
    logic [TPS_WORD_W-1:0] prim_d, sec_d;

    tps_merge u_merge (
        .hi_first (hi_a_q),
        .hi_second(hi_b_q),
        .lo_first (lo_a_q),
        .lo_second(lo_b_q),
        .prim     (prim_d),
        .sec      (sec_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prim_word <= '0;
            sec_word  <= '0;
        end else begin
            prim_word <= prim_d;
            sec_word  <= sec_d;
        end
    end

endmodule

// File: rtl/tps_track_sel_chk.sv
module tps_track_sel_chk
    import tps_pkg::*;
#(
    parameter int NCAND = TPS_NCAND
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCAND-1:0]      hi_vld,
    input logic [NCAND-1:0]      lo_vld,
    input logic [TPS_WORD_W-1:0] prim_word,
    input logic [TPS_WORD_W-1:0] sec_word
);

    localparam int CAT_B = TPS_WORD_W - 1;
    localparam int MAG_L = TPS_POS_W + TPS_HID_W;
    localparam int POS_L = TPS_HID_W;

    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    wire [TPS_POS_W-1:0] p_pos = prim_word[POS_L +: TPS_POS_W];
    wire [TPS_POS_W-1:0] s_pos = sec_word[POS_L +: TPS_POS_W];
    wire [TPS_MAG_W-1:0] p_mag = prim_word[MAG_L +: TPS_MAG_W];
    wire [TPS_MAG_W-1:0] s_mag = sec_word[MAG_L +: TPS_MAG_W];

    AST_SEC_NEEDS_PRIM: assert property (@(posedge clk) disable iff (!rst_n)
        (s_pos != '0) |-> (p_pos != '0)); // R2

    AST_SAME_CAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ((p_pos != '0) && (s_pos != '0) && (prim_word[CAT_B] == sec_word[CAT_B]))
        |-> ((p_mag > s_mag) || ((p_mag == s_mag) && (p_pos > s_pos)))); // R3

    AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        sec_word[CAT_B] |-> prim_word[CAT_B]); // R6

    AST_NOHIT_PRIM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (p_pos == '0) |-> (prim_word == '0)); // R9

    AST_NOHIT_SEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_pos == '0) |-> (sec_word == '0)); // R9

    AST_TWO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2'd3) && ($past($countones(hi_vld), 3) >= 2))
        |-> (prim_word[CAT_B] && sec_word[CAT_B])); // R5

    AST_LATENCY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2'd3) && $past(|hi_vld, 3)) |-> prim_word[CAT_B]); // R10

    AST_LATENCY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2'd3) && ($past(hi_vld, 3) == '0) && ($past(lo_vld, 3) == '0))
        |-> ((prim_word == '0) && (sec_word == '0))); // R4

endmodule

bind tps_track_sel tps_track_sel_chk #(.NCAND(NCAND)) u_tps_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_vld   (hi_vld),
    .lo_vld   (lo_vld),
    .prim_word(prim_word),
    .sec_word (sec_word)
);

// File: tb/tps_track_sel_tb_top.sv
`timescale 1ns/1ps
module tps_track_sel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  hi_vld = '0, hi_sgn = '0, hi_hid = '0;
    logic [5:0]  lo_vld = '0, lo_sgn = '0, lo_hid = '0;
    logic [23:0] hi_mag = '0, lo_mag = '0;
    logic [9:0]  prim_word, sec_word;

    always #5 clk = ~clk;

    tps_track_sel dut_i (
        .clk(clk), .rst_n(rst_n),
        .hi_vld(hi_vld), .hi_sgn(hi_sgn), .hi_mag(hi_mag), .hi_hid(hi_hid),
        .lo_vld(lo_vld), .lo_sgn(lo_sgn), .lo_mag(lo_mag), .lo_hid(lo_hid),
        .prim_word(prim_word), .sec_word(sec_word)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    logic [31:0] rs = 32'h1234_5679;

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    // Indices of best and second-best present entries (-1 if none)
    function automatic void top2(input logic [5:0] v, input logic [23:0] m, output int a, output int b);
        int sa, sb;
        a = -1; b = -1; sa = 0; sb = 0;
        for (int j = 0; j < 6; j++) begin
            if (v[j]) begin
                int sc;
                sc = int'(m[j*4 +: 4]) * 8 + j;
                if (a < 0 || sc > sa) begin
                    b = a; sb = sa; a = j; sa = sc;
                end else if (b < 0 || sc > sb) begin
                    b = j; sb = sc;
                end
            end
        end
    endfunction

    function automatic logic [9:0] word(input int cat, input int j, input logic [5:0] s,
                                        input logic [23:0] m, input logic [5:0] h);
        if (j < 0) return 10'd0;
        return 10'(cat * 512 + int'(s[j]) * 256 + int'(m[j*4 +: 4]) * 16 + (j + 1) * 2 + int'(h[j]));
    endfunction

    function automatic void model(output logic [9:0] p, output logic [9:0] s);
        int ha, hb, la, lb;
        top2(hi_vld, hi_mag, ha, hb);
        top2(lo_vld, lo_mag, la, lb);
        if (hb >= 0) begin
            p = word(1, ha, hi_sgn, hi_mag, hi_hid); s = word(1, hb, hi_sgn, hi_mag, hi_hid);
        end else if (ha >= 0) begin
            p = word(1, ha, hi_sgn, hi_mag, hi_hid); s = word(0, la, lo_sgn, lo_mag, lo_hid);
        end else begin
            p = word(0, la, lo_sgn, lo_mag, lo_hid); s = word(0, lb, lo_sgn, lo_mag, lo_hid);
        end
    endfunction

    task automatic check(input string tg, input logic [9:0] ep, input logic [9:0] es);
        nchk++;
        if (prim_word !== ep || sec_word !== es) begin
            nfail++;
            $display("FAIL %s: prim=%b sec=%b expected prim=%b sec=%b", tg, prim_word, sec_word, ep, es);
        end
    endtask

    // Streaming with a 4-deep ring of expected words (latency 3)
    logic [9:0] rp [4];
    logic [9:0] rsw [4];
    string      rt [4];
    int         nvec = 0;

    task automatic stream(input string tg);
        if (nvec >= 3) check(rt[(nvec - 3) % 4], rp[(nvec - 3) % 4], rsw[(nvec - 3) % 4]);
        begin
            logic [9:0] p, s;
            model(p, s);
            rp[nvec % 4] = p; rsw[nvec % 4] = s; rt[nvec % 4] = tg;
        end
        nvec++;
        @(negedge clk);
    endtask

    task automatic clear_in();
        hi_vld = '0; hi_sgn = '0; hi_mag = '0; hi_hid = '0;
        lo_vld = '0; lo_sgn = '0; lo_mag = '0; lo_hid = '0;
    endtask

    task automatic rand_fields(input bit narrow);
        logic [31:0] r;
        r = rnd(); hi_sgn = r[5:0]; hi_hid = r[11:6]; lo_sgn = r[17:12]; lo_hid = r[23:18];
        for (int j = 0; j < 6; j++) begin
            r = rnd();
            hi_mag[j*4 +: 4] = narrow ? 4'(r[1:0] % 3) : r[3:0];
            lo_mag[j*4 +: 4] = narrow ? 4'(r[5:4] % 3) : r[7:4];
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero during reset even with inputs present
        hi_vld = 6'h3F; hi_mag = 24'hFFFFFF; lo_vld = 6'h3F; lo_mag = 24'hFFFFFF;
        repeat (3) @(negedge clk);
        check("R1", 10'd0, 10'd0);
        clear_in();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 10'd0, 10'd0);

        // R8 and R10: one high at index 2, mag 5, positive, hid 1; observe latency
        hi_vld[2] = 1'b1; hi_sgn[2] = 1'b1; hi_mag[11:8] = 4'd5; hi_hid[2] = 1'b1;
        @(negedge clk);
        clear_in();
        check("R10", 10'd0, 10'd0);
        @(negedge clk);
        check("R10", 10'd0, 10'd0);
        @(negedge clk);
        check("R8", 10'b1_1_0101_011_1, 10'd0);
        @(negedge clk);
        check("R10", 10'd0, 10'd0);

        // R8: single low at index 0, mag 2, negative sign (-2), hid 0
        lo_vld[0] = 1'b1; lo_mag[3:0] = 4'd2;
        repeat (3) @(negedge clk);
        check("R8", 10'b0_0_0010_001_0, 10'd0);
        clear_in();
        repeat (3) @(negedge clk);
        check("R9", 10'd0, 10'd0);

        // R3: all six high equal -> indices 5 then 4
        hi_vld = 6'h3F; hi_mag = 24'h777777; hi_sgn = 6'h3F;
        repeat (3) @(negedge clk);
        check("R3", 10'b1_1_0111_110_0, 10'b1_1_0111_101_0);
        clear_in();

        // R4: absent highs with max magnitude do not displace low results
        hi_vld = '0; hi_mag = 24'hFFFFFF; hi_sgn = 6'h3F; hi_hid = 6'h3F;
        lo_vld = 6'b000011; lo_mag = 24'h000031; lo_sgn = 6'b000001;
        repeat (3) @(negedge clk);
        check("R4", 10'b0_0_0011_010_0, 10'b0_1_0001_001_0);
        clear_in();
        repeat (3) @(negedge clk);

        // Exhaustive sweep over both valid masks (R5, R6, R7)
        for (int hm = 0; hm < 64; hm++) begin
            for (int lm = 0; lm < 64; lm++) begin
                int hc;
                rand_fields(1'b0);
                hi_vld = 6'(hm); lo_vld = 6'(lm);
                hc = $countones(hi_vld);
                stream(hc >= 2 ? "R5" : (hc == 1 ? "R6" : "R7"));
            end
        end
        // Tie-heavy pass (R3)
        for (int k = 0; k < 1000; k++) begin
            logic [31:0] r;
            rand_fields(1'b1);
            r = rnd(); hi_vld = r[5:0]; lo_vld = r[11:6];
            stream("R3");
        end
        // All present, full magnitudes (R2)
        for (int k = 0; k < 1000; k++) begin
            rand_fields(1'b0);
            hi_vld = 6'h3F; lo_vld = 6'h3F;
            stream("R2");
        end
        // Absent entries loaded with maximum magnitude (R4)
        for (int k = 0; k < 1000; k++) begin
            logic [31:0] r;
            rand_fields(1'b0);
            r = rnd(); hi_vld = r[5:0] & r[13:8]; lo_vld = r[21:16];
            for (int j = 0; j < 6; j++) begin
                if (!hi_vld[j]) hi_mag[j*4 +: 4] = 4'hF;
                if (!lo_vld[j]) lo_mag[j*4 +: 4] = 4'hF;
            end
            stream("R4");
        end
        clear_in();
        repeat (3) stream("R9");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule